// File: doc/BRIEF.md
# Audio Clock Monitor and Power Sequencer

This block watches the three clocks of a serial audio link (system clock, bit clock and word clock) from a free-running reference oscillator and decides how the converter behind it runs. On each word-clock frame it counts system-clock rising edges and bit-clock rising edges. When the system-clock count per frame equals one of the twelve supported ratios in two frames in a row, the block enters external-clock mode and reports which ratio it found. When no system clock is present, it counts frames whose bit clock and word clock are well formed. After sixteen such frames in a row it selects a mode in which the converter's clock is derived from the bit clock.

While it runs, the block tracks the word-clock phase against the locked ratio and tolerates a small drift. A larger drift, a malformed frame or a halted clock sends it back to standby with a single-cycle reinitialise strobe. If the bit and word clocks both stay low for a long time, it enters power-down. When the clocks come back, it leaves power-down and acquires again without help. After reset a hold interval keeps the block in standby before any decision is taken.

Top module: `audio_clk_sequencer`

## Requirements
- R1: For POR_CYCLES reference cycles after reset release, modeSel stays 0 (none), standby stays 1, powerDown stays 0 and ratioCode stays 0, even with valid clocks applied.
- R2: With the system clock present, a bit-clock count of 32, 48 or 64 per frame, and the same supported system-clock count per frame in two consecutive frames, modeSel becomes 1 (external), standby becomes 0, and ratioCode gives the ratio's position in the ascending list 64, 128, 192, 256, 384, 512, 768, 1024, 1152, 1536, 2048, 3072, numbered 1 to 12.
- R3: A system-clock count per frame that is not in the supported list never yields external mode; the block stays in standby with modeSel 0.
- R4: With no system clock and valid bit and word clocks, modeSel becomes 2 (internal) only once 16 consecutive well-formed frames have been seen; after 13 such frames it is still 0.
- R5: In internal mode, any system-clock edge ends internal mode with a reinitialise strobe, and the block then locks to the external clock.
- R6: In external mode, a frame whose system-clock count differs from the locked ratio by at most DRIFT_TOL (5) cycles is tolerated with no strobe; a larger difference gives one reinitialise strobe and standby.
- R7: A bit-clock count per frame other than 32, 48 or 64 is a clock error: it ends a running mode with a reinitialise strobe and prevents a new lock.
- R8: When any clock stops toggling for HALT_CYCLES reference cycles while running, the block returns to standby (modeSel 0, standby 1) with one reinitialise strobe.
- R9: When bit clock and word clock are both low for PD_CYCLES reference cycles, powerDown becomes 1, with standby 1 and modeSel 0.
- R10: When bit clock and word clock toggle again, powerDown returns to 0 and the block acquires a lock again by itself.
- R11: reinitPulse lasts exactly one reference cycle and is raised only when a running mode is left.
- R12: ratioCode is 0 whenever modeSel is not 1.
- R13: A held-low bit clock while the word clock keeps toggling does not cause power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference oscillator |
| rstN | input | 1 | Active-low asynchronous reset |
| sysClkPin | input | 1 | System clock, sampled by refClk |
| bitClkPin | input | 1 | Serial bit clock, sampled by refClk |
| wordClkPin | input | 1 | Word clock; a rising edge starts a frame |
| modeSel | output | 2 | 0 none, 1 external clock, 2 bit-clock-derived clock |
| ratioCode | output | 4 | Locked ratio, 1..12 in ascending order; 0 when not external |
| reinitPulse | output | 1 | One-cycle reinitialise strobe on leaving a running mode |
| standby | output | 1 | High whenever no mode is running |
| powerDown | output | 1 | High in the deep power-down state |

## Verification
The hardest state to reach from the ports is internal-clock mode at an exact frame count. The system-clock halt detector must already be saturated before the first good frame, or some frames fail to count. The stimulus therefore parks every clock low for longer than the halt window but shorter than the power-down window, and then sends frames with no system clock. This places the sixteen-frame boundary at a known frame. Drift tolerance is reached by stretching a single frame by a chosen number of extra system-clock cycles while the bit-clock count stays unchanged. Locks at random ratios and bit-clock counts come from a seeded generator.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  localparam int NUM_RATIOS = 12;
  localparam int MAX_RATIO  = 3072;
  localparam int MAX_BCK    = 64;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_EXT  = 2'd1,
    MODE_INT  = 2'd2
  } clk_mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic goodInc;
    logic goodClr;
    logic lockLoad;
  } dp_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic       frameDone;
    logic       codeRepeat;
    logic       driftErr;
    logic       bckOk;
    logic       sckHalt;
    logic       bckHalt;
    logic       lrckHalt;
    logic       bothLowLong;
    logic       goodReached;
    logic [3:0] lockedCode;
  } dp_status_t;

  // supported system-clock cycles per frame, ascending
  function automatic int unsigned ratioOf(input int idx);
    case (idx)
      0:  ratioOf = 64;
      1:  ratioOf = 128;
      2:  ratioOf = 192;
      3:  ratioOf = 256;
      4:  ratioOf = 384;
      5:  ratioOf = 512;
      6:  ratioOf = 768;
      7:  ratioOf = 1024;
      8:  ratioOf = 1152;
      9:  ratioOf = 1536;
      10: ratioOf = 2048;
      default: ratioOf = 3072;
    endcase
  endfunction

endpackage

// File: rtl/clkmon_datapath.sv
module clkmon_datapath
  import clkmon_pkg::*;
#(
  parameter int HALT_CYCLES = 8192,
  parameter int PD_CYCLES   = 24576000,
  parameter int GOOD_FRAMES = 16,
  parameter int DRIFT_TOL   = 5
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       sysClkPin,
  input  logic       bitClkPin,
  input  logic       wordClkPin,
  input  dp_strobe_t strobe,
  output dp_status_t status
);

  localparam int NUM_CLK = 3;
  localparam int CNT_W   = $clog2(2 * MAX_RATIO);
  localparam int TOT_W   = CNT_W + 2;
  localparam int BCK_W   = $clog2(4 * MAX_BCK);
  localparam int HALT_W  = $clog2(HALT_CYCLES + 1);
  localparam int PD_W    = $clog2(PD_CYCLES + 1);
  localparam int GOOD_W  = $clog2(GOOD_FRAMES + 1);

  // ---- sampling and edge detection ----
  logic [NUM_CLK-1:0] pinVec, syncA, syncB, lastB, riseVec, edgeVec, haltVec;
  assign pinVec = {wordClkPin, bitClkPin, sysClkPin};

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      lastB <= '0;
    end else begin
      syncA <= pinVec;
      syncB <= syncA;
      lastB <= syncB;
    end
  end

  assign riseVec = syncB & ~lastB;
  assign edgeVec = syncB ^ lastB;

  // ---- per-clock idle counters ----
  for (genvar g = 0; g < NUM_CLK; g++) begin : g_idle
    logic [HALT_W-1:0] idleCnt;
    always_ff @(posedge refClk or negedge rstN) begin
      if (!rstN)                                idleCnt <= HALT_W'(HALT_CYCLES);
      else if (edgeVec[g])                      idleCnt <= '0;
      else if (idleCnt != HALT_W'(HALT_CYCLES)) idleCnt <= idleCnt + 1'b1;
    end
    assign haltVec[g] = (idleCnt == HALT_W'(HALT_CYCLES));
  end

  logic sckRise, bckRise, frameEdge;
  assign sckRise   = riseVec[0];
  assign bckRise   = riseVec[1];
  assign frameEdge = riseVec[2];

  // ---- per-frame edge counters ----
  logic [CNT_W-1:0] sckCnt;
  logic [BCK_W-1:0] bckCnt;
  logic [TOT_W-1:0] sckTotal;
  logic [BCK_W:0]   bckTotal;

  assign sckTotal = TOT_W'(sckCnt) + TOT_W'(sckRise);
  assign bckTotal = (BCK_W + 1)'(bckCnt) + (BCK_W + 1)'(bckRise);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      sckCnt <= '0;
      bckCnt <= '0;
    end else if (frameEdge) begin
      sckCnt <= '0;
      bckCnt <= '0;
    end else begin
      if (sckRise && sckCnt != '1) sckCnt <= sckCnt + 1'b1;
      if (bckRise && bckCnt != '1) bckCnt <= bckCnt + 1'b1;
    end
  end

  // ---- ratio comparator bank ----
  logic [NUM_RATIOS-1:0] hitVec;
  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_hit
    assign hitVec[g] = (sckTotal == TOT_W'(ratioOf(g)));
  end

  logic [3:0] hitCode;
  always_comb begin
    hitCode = '0;
    for (int i = 0; i < NUM_RATIOS; i++)
      if (hitVec[i]) hitCode = 4'(i + 1);
  end

  // ---- locked ratio and drift window ----
  logic [3:0]       lockedCode, frameCodeR;
  logic [TOT_W-1:0] lockedRatio;

  always_comb begin
    lockedRatio = '0;
    for (int i = 0; i < NUM_RATIOS; i++)
      if (lockedCode == 4'(i + 1)) lockedRatio = TOT_W'(ratioOf(i));
  end

  logic driftNow, bckNow;
  assign driftNow = (sckTotal > lockedRatio + TOT_W'(DRIFT_TOL)) ||
                    (sckTotal + TOT_W'(DRIFT_TOL) < lockedRatio);
  assign bckNow   = (bckTotal == (BCK_W + 1)'(32)) ||
                    (bckTotal == (BCK_W + 1)'(48)) ||
                    (bckTotal == (BCK_W + 1)'(64));

  logic frameDoneR, codeRepeatR, driftErrR, bckOkR;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      frameDoneR  <= 1'b0;
      frameCodeR  <= '0;
      codeRepeatR <= 1'b0;
      driftErrR   <= 1'b0;
      bckOkR      <= 1'b0;
    end else begin
      frameDoneR <= frameEdge;
      if (frameEdge) begin
        frameCodeR  <= hitCode;
        codeRepeatR <= (hitCode == frameCodeR) && (hitCode != '0);
        driftErrR   <= driftNow;
        bckOkR      <= bckNow;
      end
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                lockedCode <= '0;
    else if (strobe.lockLoad) lockedCode <= frameCodeR;
  end

  // ---- good-frame run counter for the internal-clock decision ----
  logic [GOOD_W-1:0] goodCnt;
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                 goodCnt <= '0;
    else if (strobe.goodClr)   goodCnt <= '0;
    else if (strobe.goodInc && goodCnt != GOOD_W'(GOOD_FRAMES))
      goodCnt <= goodCnt + 1'b1;
  end

  // ---- long-low timer for power-down ----
  logic [PD_W-1:0] lowCnt;
  logic            bothLow;
  assign bothLow = !syncB[1] && !syncB[2];

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                          lowCnt <= '0;
    else if (!bothLow)                  lowCnt <= '0;
    else if (lowCnt != PD_W'(PD_CYCLES)) lowCnt <= lowCnt + 1'b1;
  end

  assign status.frameDone   = frameDoneR;
  assign status.codeRepeat  = codeRepeatR;
  assign status.driftErr    = driftErrR;
  assign status.bckOk       = bckOkR;
  assign status.sckHalt     = haltVec[0];
  assign status.bckHalt     = haltVec[1];
  assign status.lrckHalt    = haltVec[2];
  assign status.bothLowLong = (lowCnt == PD_W'(PD_CYCLES));
  assign status.goodReached = (goodCnt == GOOD_W'(GOOD_FRAMES));
  assign status.lockedCode  = lockedCode;

endmodule

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl
  import clkmon_pkg::*;
#(
  parameter int POR_CYCLES = 98304
) (
  input  logic       refClk,
  input  logic       rstN,
  input  dp_status_t status,
  output dp_strobe_t strobe,
  output clk_mode_e  mode,
  output logic [3:0] ratioCode,
  output logic       reinitPulse,
  output logic       standby,
  output logic       powerDown
);

  localparam int POR_W = $clog2(POR_CYCLES + 1);

  typedef enum logic [2:0] {
    ST_POR, ST_STANDBY, ST_EXT, ST_INT, ST_PDOWN
  } seq_state_e;

  seq_state_e       state, stateNext;
  logic [POR_W-1:0] porCnt;
  logic             reinitR, leaveRun;

  logic extErr, intErr;
  assign extErr = status.sckHalt || status.bckHalt || status.lrckHalt ||
                  status.bothLowLong ||
                  (status.frameDone && (status.driftErr || !status.bckOk));
  assign intErr = !status.sckHalt || status.bckHalt || status.lrckHalt ||
                  status.bothLowLong || (status.frameDone && !status.bckOk);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    leaveRun  = 1'b0;
    case (state)
      ST_POR: begin
        if (porCnt == POR_W'(POR_CYCLES - 1)) begin
          stateNext      = ST_STANDBY;
          strobe.goodClr = 1'b1;
        end
      end
      ST_STANDBY: begin
        if (status.bothLowLong) begin
          stateNext      = ST_PDOWN;
          strobe.goodClr = 1'b1;
        end else if (status.goodReached) begin
          stateNext      = ST_INT;
          strobe.goodClr = 1'b1;
        end else if (status.bckHalt || status.lrckHalt) begin
          strobe.goodClr = 1'b1;
        end else if (status.frameDone) begin
          if (!status.sckHalt && status.bckOk && status.codeRepeat) begin
            stateNext       = ST_EXT;
            strobe.lockLoad = 1'b1;
            strobe.goodClr  = 1'b1;
          end else if (status.sckHalt && status.bckOk) begin
            strobe.goodInc = 1'b1;
          end else begin
            strobe.goodClr = 1'b1;
          end
        end
      end
      ST_EXT: begin
        if (extErr) begin
          stateNext      = ST_STANDBY;
          leaveRun       = 1'b1;
          strobe.goodClr = 1'b1;
        end
      end
      ST_INT: begin
        if (intErr) begin
          stateNext      = ST_STANDBY;
          leaveRun       = 1'b1;
          strobe.goodClr = 1'b1;
        end
      end
      ST_PDOWN: begin
        if (!status.bckHalt && !status.lrckHalt) begin
          stateNext      = ST_STANDBY;
          strobe.goodClr = 1'b1;
        end
      end
      default: stateNext = ST_STANDBY;
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_POR;
      porCnt  <= '0;
      reinitR <= 1'b0;
    end else begin
      state   <= stateNext;
      reinitR <= leaveRun;
      if (state == ST_POR) porCnt <= porCnt + 1'b1;
    end
  end

  always_comb begin
    case (state)
      ST_EXT:  mode = MODE_EXT;
      ST_INT:  mode = MODE_INT;
      default: mode = MODE_NONE;
    endcase
  end

  assign ratioCode   = (state == ST_EXT) ? status.lockedCode : 4'd0;
  assign reinitPulse = reinitR;
  assign standby     = (state != ST_EXT) && (state != ST_INT);
  assign powerDown   = (state == ST_PDOWN);

endmodule

// File: rtl/audio_clk_sequencer.sv
module audio_clk_sequencer
  import clkmon_pkg::*;
#(
  parameter int POR_CYCLES  = 98304,
  parameter int HALT_CYCLES = 8192,
  parameter int PD_CYCLES   = 24576000,
  parameter int GOOD_FRAMES = 16,
  parameter int DRIFT_TOL   = 5
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       sysClkPin,
  input  logic       bitClkPin,
  input  logic       wordClkPin,
  output logic [1:0] modeSel,
  output logic [3:0] ratioCode,
  output logic       reinitPulse,
  output logic       standby,
  output logic       powerDown
);

  dp_strobe_t dpStrobe;
  dp_status_t dpStatus;
  clk_mode_e  modeInt;

  clkmon_datapath #(
    .HALT_CYCLES(HALT_CYCLES),
    .PD_CYCLES  (PD_CYCLES),
    .GOOD_FRAMES(GOOD_FRAMES),
    .DRIFT_TOL  (DRIFT_TOL)
  ) u_dp (
    .refClk    (refClk),
    .rstN      (rstN),
    .sysClkPin (sysClkPin),
    .bitClkPin (bitClkPin),
    .wordClkPin(wordClkPin),
    .strobe    (dpStrobe),
    .status    (dpStatus)
  );

  clkmon_ctrl #(
    .POR_CYCLES(POR_CYCLES)
  ) u_ctrl (
    .refClk     (refClk),
    .rstN       (rstN),
    .status     (dpStatus),
    .strobe     (dpStrobe),
    .mode       (modeInt),
    .ratioCode  (ratioCode),
    .reinitPulse(reinitPulse),
    .standby    (standby),
    .powerDown  (powerDown)
  );

  assign modeSel = modeInt;

endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker #(
  parameter int POR_CYCLES = 98304
) (
  input logic       refClk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic [3:0] ratioCode,
  input logic       reinitPulse,
  input logic       standby,
  input logic       powerDown,
  input logic       sckHalt,
  input logic       bckHalt
);

  localparam int AGE_W = $clog2(POR_CYCLES + 1);
  logic [AGE_W-1:0] porAge;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                               porAge <= '0;
    else if (porAge != AGE_W'(POR_CYCLES))   porAge <= porAge + 1'b1;
  end

  // R1: nothing runs during the hold interval
  p_por_hold_r1: assert property (@(posedge refClk) disable iff (!rstN)
    (porAge < AGE_W'(POR_CYCLES)) |-> (modeSel == 2'd0 && standby && !powerDown));

  // R2: external mode always reports a code in range
  p_code_valid_r2: assert property (@(posedge refClk) disable iff (!rstN)
    (modeSel == 2'd1) |-> (ratioCode >= 4'd1 && ratioCode <= 4'd12));

  // R12: no code outside external mode
  p_code_zero_r12: assert property (@(posedge refClk) disable iff (!rstN)
    (modeSel != 2'd1) |-> (ratioCode == 4'd0));

  // R5: a system-clock edge ends internal mode on the next cycle
  p_int_leaves_r5: assert property (@(posedge refClk) disable iff (!rstN)
    (modeSel == 2'd2 && !sckHalt) |=> (modeSel != 2'd2));

  // R8: a halted bit clock ends any running mode
  p_halt_exit_r8: assert property (@(posedge refClk) disable iff (!rstN)
    (modeSel != 2'd0 && bckHalt) |=> (modeSel == 2'd0));

  // R9: power-down implies standby and no mode
  p_pdown_standby_r9: assert property (@(posedge refClk) disable iff (!rstN)
    powerDown |-> (standby && modeSel == 2'd0));

  // R11: strobe is one cycle wide and only follows a running mode
  p_reinit_single_r11: assert property (@(posedge refClk) disable iff (!rstN)
    reinitPulse |=> !reinitPulse);

  p_reinit_from_run_r11: assert property (@(posedge refClk) disable iff (!rstN)
    reinitPulse |-> (standby && modeSel == 2'd0 && $past(modeSel) != 2'd0));

  // R2: running and standby are exclusive
  p_run_not_standby_r2: assert property (@(posedge refClk) disable iff (!rstN)
    (modeSel != 2'd0) |-> !standby);

endmodule

bind audio_clk_sequencer clkmon_checker #(.POR_CYCLES(POR_CYCLES)) u_chk (
  .refClk     (refClk),
  .rstN       (rstN),
  .modeSel    (modeSel),
  .ratioCode  (ratioCode),
  .reinitPulse(reinitPulse),
  .standby    (standby),
  .powerDown  (powerDown),
  .sckHalt    (dpStatus.sckHalt),
  .bckHalt    (dpStatus.bckHalt)
);

// File: tb/tb_audio_clk_sequencer.sv
module tb_audio_clk_sequencer;

  localparam int CLK_PERIOD  = 10;
  localparam int POR_CYCLES  = 1500;
  localparam int HALT_CYCLES = 4000;
  localparam int PD_CYCLES   = 5000;
  localparam int WATCHDOG    = 190000;

  logic       refClk = 1'b0;
  logic       rstN   = 1'b0;
  logic       sck = 1'b0, bck = 1'b0, lrck = 1'b0;
  logic [1:0] modeSel;
  logic [3:0] ratioCode;
  logic       reinitPulse, standby, powerDown;

  int checkCount = 0;
  int failCount  = 0;
  int reinitSeen = 0;
  int widthErr   = 0;
  logic lastReinit = 1'b0;
  bit   finished   = 1'b0;

  always #(CLK_PERIOD / 2) refClk = ~refClk;

  audio_clk_sequencer #(
    .POR_CYCLES (POR_CYCLES),
    .HALT_CYCLES(HALT_CYCLES),
    .PD_CYCLES  (PD_CYCLES),
    .GOOD_FRAMES(16),
    .DRIFT_TOL  (5)
  ) dut (
    .refClk     (refClk),
    .rstN       (rstN),
    .sysClkPin  (sck),
    .bitClkPin  (bck),
    .wordClkPin (lrck),
    .modeSel    (modeSel),
    .ratioCode  (ratioCode),
    .reinitPulse(reinitPulse),
    .standby    (standby),
    .powerDown  (powerDown)
  );

  // strobe monitor at the ports, away from the active edge
  always @(negedge refClk) begin
    if (rstN) begin
      if (reinitPulse) begin
        reinitSeen++;
        if (lastReinit) widthErr++;
      end
      lastReinit = reinitPulse;
    end
  end

  function automatic int benchRatio(input int idx);
    int t [12] = '{64, 128, 192, 256, 384, 512, 768, 1024, 1152, 1536, 2048, 3072};
    return t[idx];
  endfunction

  function automatic int expCode(input int ratio);
    for (int i = 0; i < 12; i++)
      if (benchRatio(i) == ratio) return i + 1;
    return 0;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checkCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  // one frame = 2*ratio reference cycles plus 2*extra stretch cycles
  task automatic runFrames(input int n, input int ratio, input int bpf,
                           input bit withSck, input int extra);
    for (int f = 0; f < n; f++) begin
      int base = 2 * ratio;
      int half = (bpf == 0) ? 1 : base / (2 * bpf);
      for (int t = 0; t < base + 2 * extra; t++) begin
        @(negedge refClk);
        sck  = withSck ? (t % 2 == 0) : 1'b0;
        bck  = (bpf != 0 && t < base) ? ((t / half) % 2 == 0) : 1'b0;
        lrck = (t < base / 2);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int t = 0; t < n; t++) begin
      @(negedge refClk);
      sck = 1'b0; bck = 1'b0; lrck = 1'b0;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge refClk);
    failCount++;
    checkCount++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int snap;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge refClk);
    rstN = 1'b1;
    @(negedge refClk);

    // R1: reset state and hold with clocks running
    check("R1 reset mode", modeSel, 0);
    check("R1 reset standby", standby, 1);
    check("R1 reset powerDown", powerDown, 0);
    check("R12 reset code", ratioCode, 0);
    runFrames(2, 256, 64, 1, 0);
    check("R1 hold mode", modeSel, 0);
    check("R1 hold standby", standby, 1);
    runFrames(3, 256, 64, 1, 0);
    check("R2 lock after hold mode", modeSel, 1);
    check("R2 lock code 256", ratioCode, expCode(256));
    check("R2 standby low", standby, 0);

    // R2: random ratios and bit-clock counts
    for (int k = 0; k < 5; k++) begin
      int idx = int'($urandom % 10);
      int bpf = ($urandom % 2) ? 64 : 32;
      runFrames(4, benchRatio(idx), bpf, 1, 0);
      check("R2 random mode", modeSel, 1);
      check("R2 random code", ratioCode, idx + 1);
    end
    runFrames(4, 3072, 64, 1, 0);
    check("R2 top ratio code", ratioCode, 12);
    runFrames(4, 64, 64, 1, 0);
    check("R2 bottom ratio code", ratioCode, 1);

    // R6: drift tolerance
    runFrames(4, 256, 64, 1, 0);
    snap = reinitSeen;
    runFrames(1, 256, 64, 1, 3);
    runFrames(2, 256, 64, 1, 0);
    check("R6 small drift mode", modeSel, 1);
    check("R6 small drift no strobe", reinitSeen, snap);
    runFrames(1, 256, 64, 1, 8);
    runFrames(1, 256, 64, 1, 0);
    check("R6 large drift strobe", reinitSeen, snap + 1);
    runFrames(3, 256, 64, 1, 0);
    check("R6 relock", modeSel, 1);

    // R3: unsupported ratios
    runFrames(4, 320, 64, 1, 0);
    check("R3 ratio 320 mode", modeSel, 0);
    runFrames(4, 160, 32, 1, 0);
    check("R3 ratio 160 mode", modeSel, 0);
    check("R3 standby", standby, 1);

    // R7: malformed bit clock
    runFrames(4, 256, 64, 1, 0);
    snap = reinitSeen;
    runFrames(2, 256, 16, 1, 0);
    check("R7 bad bck mode", modeSel, 0);
    check("R7 bad bck strobe", reinitSeen, snap + 1);
    runFrames(3, 256, 16, 1, 0);
    check("R7 bad bck no lock", modeSel, 0);

    // R4: internal-clock mode
    idle(HALT_CYCLES + 100);
    check("R4 idle no powerdown", powerDown, 0);
    runFrames(14, 128, 64, 0, 0);
    check("R4 13 frames still none", modeSel, 0);
    runFrames(4, 128, 64, 0, 0);
    check("R4 internal mode", modeSel, 2);
    check("R12 internal code zero", ratioCode, 0);

    // R5: system clock returns
    snap = reinitSeen;
    runFrames(4, 256, 64, 1, 0);
    check("R5 back to external", modeSel, 1);
    check("R5 strobe", reinitSeen, snap + 1);

    // R8: halt
    snap = reinitSeen;
    idle(HALT_CYCLES + 50);
    check("R8 halt mode", modeSel, 0);
    check("R8 halt standby", standby, 1);
    check("R8 halt strobe", reinitSeen, snap + 1);
    check("R8 no powerdown yet", powerDown, 0);

    // R9: power-down
    idle(1000);
    check("R9 powerDown", powerDown, 1);
    check("R9 standby", standby, 1);

    // R10: recovery
    runFrames(4, 256, 64, 1, 0);
    check("R10 powerDown cleared", powerDown, 0);
    check("R10 relocked", modeSel, 1);

    // R13: bit clock held low, word clock running
    snap = reinitSeen;
    runFrames(12, 256, 0, 1, 0);
    check("R13 no powerdown", powerDown, 0);
    check("R13 mode none", modeSel, 0);
    check("R7 held bck strobe", reinitSeen, snap + 1);

    // R11: strobe width
    check("R11 strobe width", widthErr, 0);

    summary();
  end

endmodule